// File: doc/BRIEF.md
# Per-Pin Interrupt Detector for a Parallel Input Port

This block watches a parallel input port of configurable width and turns pin activity into a single interrupt request for the system interrupt controller. Each pin owns a small mode register. Two bits of it choose the interrupt condition: off, high level, low level, or change. Three more bits hold a drive mode, one of eight values, which is only stored and passed to the pad ring. Pin inputs go through a two-flop synchronizer before any detection or readback.

Change detection does not look at the previous clock sample. It compares each pin with a reference copy that is taken whenever the CPU reads the port. Software therefore gets an interrupt for anything that differs from what it last saw. The CPU uses a simple single-cycle register bus. Reading the port returns the synchronized pins. Writing the pending register clears change-mode pending bits, one bit per pin, wherever a one is written. Each pin's mode register can be written and read back.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, all pending bits, `irq_o`, every mode register and `drive_mode_o` read as zero. Interrupt mode 00 means off.
- R2: A pin change applied before a clock edge shows in a port read (address 0, bit i = pin i) after the second rising edge and not after the first.
- R3: In high-level mode (01), a pin's pending bit (address 1, bit i) is set one edge after the synchronized pin is high. It clears one edge after the pin goes low.
- R4: In low-level mode (10), a pin's pending bit is set while the synchronized pin is low and clears when it goes high.
- R5: In change mode (11), a pending bit is set when the synchronized pin differs from the reference. It stays set even if the pin returns to the reference value.
- R6: A port read copies the synchronized pins into the reference and clears every change-mode pending bit at that edge.
- R7: Writing address 1 clears the change-mode pending bits written as 1. Bits written as 0 are kept, level-mode bits are not affected, and the reference is unchanged.
- R8: A pin in mode off never sets its pending bit.
- R9: `irq_o` is high exactly when at least one pending bit is set.
- R10: The mode register of pin i is at address 2+i. Bits [1:0] hold the interrupt mode and bits [4:2] the drive mode. It reads back as written, and its drive field appears on `drive_mode_o[3i+2:3i]`.
- R11: Writing a pin's mode register clears that pin's pending bit at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Raw asynchronous pin levels |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Register address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, combinational from address |
| drive_mode_o | output | 3*NUM_PINS | Per-pin drive mode to the pads |
| irq_o | output | 1 | Combined interrupt request, active high |

## Verification
The assertions assume that every register access lasts exactly one cycle, with `bus_sel_i` high. They also assume that the read side effects land on the edge that ends that cycle. The level and change properties also assume the synchronized pin is stable for the cycle being judged, which holds because it comes from flops. The stimulus drives the bus and pins only on falling edges and issues one access per cycle. Between steps it lets each pin change settle through the synchronizer for a counted number of edges, so that every expected value lands in a known cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int IRQ_W  = 2;
  localparam int DRV_W  = 3;
  localparam int MODE_W = IRQ_W + DRV_W;

  localparam int ADDR_PORT  = 0;
  localparam int ADDR_PEND  = 1;
  localparam int ADDR_MODE0 = 2;

  typedef enum logic [IRQ_W-1:0] {
    IRQ_OFF  = 2'b00,
    IRQ_HIGH = 2'b01,
    IRQ_LOW  = 2'b10,
    IRQ_CHG  = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
  import gpio_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_s_i,
  input  logic              port_rd_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              clr_i,
  output logic [IRQ_W-1:0]  irq_mode_o,
  output logic [DRV_W-1:0]  drive_o,
  output logic              pend_o
);
  irq_mode_e        mode_q;
  logic [DRV_W-1:0] drive_q;
  logic             ref_q, pend_q, pend_d;

  always_comb begin
    unique case (mode_q)
      IRQ_OFF:  pend_d = 1'b0;
      IRQ_HIGH: pend_d = pin_s_i;
      IRQ_LOW:  pend_d = !pin_s_i;
      default:  pend_d = (port_rd_i || clr_i) ? 1'b0 : (pend_q | (pin_s_i ^ ref_q));
    endcase
    if (mode_we_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= IRQ_OFF;
      drive_q <= '0;
      ref_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (port_rd_i) ref_q <= pin_s_i;
      if (mode_we_i) begin
        mode_q  <= irq_mode_e'(mode_wdata_i[IRQ_W-1:0]);
        drive_q <= mode_wdata_i[MODE_W-1:IRQ_W];
      end
    end
  end

  assign irq_mode_o = mode_q;
  assign drive_o    = drive_q;
  assign pend_o     = pend_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DW       = 8,
  localparam int AW      = $clog2(NUM_PINS + ADDR_MODE0)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       pin_i,
  input  logic                      bus_sel_i,
  input  logic                      bus_we_i,
  input  logic [AW-1:0]             bus_addr_i,
  input  logic [DW-1:0]             bus_wdata_i,
  output logic [DW-1:0]             bus_rdata_o,
  output logic [DRV_W*NUM_PINS-1:0] drive_mode_o,
  output logic                      irq_o
);
  logic [NUM_PINS-1:0]       pin_s, pend, mode_we, clr;
  logic [IRQ_W*NUM_PINS-1:0] irq_mode_vec;
  logic [MODE_W-1:0]         mode_rd [NUM_PINS];
  logic                      rd_acc, wr_acc, port_rd;

  assign rd_acc  = bus_sel_i && !bus_we_i;
  assign wr_acc  = bus_sel_i && bus_we_i;
  assign port_rd = rd_acc && (bus_addr_i == AW'(ADDR_PORT));
  assign clr     = (wr_acc && (bus_addr_i == AW'(ADDR_PEND))) ? bus_wdata_i[NUM_PINS-1:0] : '0;

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign mode_we[i] = wr_acc && (bus_addr_i == AW'(ADDR_MODE0 + i));

    gpio_pin_ctl u_ctl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pin_s_i      (pin_s[i]),
      .port_rd_i    (port_rd),
      .mode_we_i    (mode_we[i]),
      .mode_wdata_i (bus_wdata_i[MODE_W-1:0]),
      .clr_i        (clr[i]),
      .irq_mode_o   (irq_mode_vec[IRQ_W*i +: IRQ_W]),
      .drive_o      (drive_mode_o[DRV_W*i +: DRV_W]),
      .pend_o       (pend[i])
    );

    assign mode_rd[i] = {drive_mode_o[DRV_W*i +: DRV_W], irq_mode_vec[IRQ_W*i +: IRQ_W]};
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == AW'(ADDR_PORT)) bus_rdata_o[NUM_PINS-1:0] = pin_s;
    else if (bus_addr_i == AW'(ADDR_PEND)) bus_rdata_o[NUM_PINS-1:0] = pend;
    for (int i = 0; i < NUM_PINS; i++)
      if (bus_addr_i == AW'(ADDR_MODE0 + i)) bus_rdata_o[MODE_W-1:0] = mode_rd[i];
  end

  assign irq_o = |pend;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  irq_o,
  input logic [NUM_PINS-1:0]   pin_s,
  input logic [NUM_PINS-1:0]   pend,
  input logic [NUM_PINS-1:0]   mode_we,
  input logic [NUM_PINS-1:0]   clr,
  input logic [2*NUM_PINS-1:0] irq_mode_vec,
  input logic                  port_rd
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !irq_o); // R1

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    AST_OFF_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_mode_vec[2*i +: 2] == 2'b00) |=> !pend[i]); // R8
    AST_HIGH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_mode_vec[2*i +: 2] == 2'b01 && pin_s[i] && !mode_we[i]) |=> pend[i]); // R3
    AST_LOW_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_mode_vec[2*i +: 2] == 2'b10 && !pin_s[i] && !mode_we[i]) |=> pend[i]); // R4
    AST_CHG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_mode_vec[2*i +: 2] == 2'b11 && pend[i] && !port_rd && !clr[i] && !mode_we[i]) |=> pend[i]); // R5
    AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_mode_vec[2*i +: 2] == 2'b11 && port_rd) |=> !pend[i]); // R6
    AST_MODE_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_we[i] |=> !pend[i]); // R11
  end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_o        (irq_o),
  .pin_s        (pin_s),
  .pend         (pend),
  .mode_we      (mode_we),
  .clr          (clr),
  .irq_mode_vec (irq_mode_vec),
  .port_rd      (port_rd)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  localparam int N  = 8;
  localparam int DW = 8;
  localparam int AW = $clog2(N + 2);
  localparam int K_RD = 0, K_IRQ = 1, K_DRV = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    pins = '0;
  logic            sel = 1'b0, we = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [DW-1:0]   wdata = '0;
  logic [DW-1:0]   rdata;
  logic [3*N-1:0]  drv;
  logic            irq;
  logic            probe = 1'b0;
  int              n_chk = 0, n_fail = 0;
  bit              done = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  gpio_irq_port #(.NUM_PINS(N), .DW(DW)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pin_i        (pins),
    .bus_sel_i    (sel),
    .bus_we_i     (we),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .drive_mode_o (drv),
    .irq_o        (irq)
  );

  // driver: one operation per cycle, applied on the falling edge
  task automatic op(input logic s, input logic w, input int a, input int d,
                    input int kind, input logic [31:0] exp, input string tag);
    @(negedge clk);
    sel = s; we = w; addr = AW'(a); wdata = DW'(d);
    if (kind >= 0) begin
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      probe = 1'b1;
    end else probe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, -1, 0, "");
  endtask
  task automatic setp(input int v);
    @(negedge clk);
    pins = N'(v); sel = 0; we = 0; probe = 0;
  endtask
  task automatic wr(input int a, input int d);
    op(1, 1, a, d, -1, 0, "");
  endtask
  task automatic rd(input int a, input int e, input string tag);
    op(1, 0, a, 0, K_RD, 32'(e), tag);
  endtask
  task automatic irq_chk(input int e, input string tag);
    op(0, 0, 0, 0, K_IRQ, 32'(e), tag);
  endtask
  task automatic drv_chk(input int e, input string tag);
    op(0, 0, 0, 0, K_DRV, 32'(e), tag);
  endtask

  // monitor: samples late in the cycle, pops the matching expectation
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (probe && sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_RD:    act = 32'(rdata);
          K_IRQ:   act = 32'(irq);
          default: act = 32'(drv);
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1, 8'h00, "R1 pend");
    rd(0, 8'h00, "R1 port");
    rd(2, 8'h00, "R1 mode0");
    irq_chk(0, "R1 irq");
    drv_chk(0, "R1 drive");
    // R10 mode write, readback, drive export
    wr(2, 8'h15);
    rd(2, 8'h15, "R10 mode0 readback");
    drv_chk(24'h000005, "R10 drive pin0");
    // R2 synchronizer latency, R8 off mode
    setp(8'h02);
    rd(0, 8'h00, "R2 one edge");
    rd(0, 8'h02, "R2 two edges");
    idle(2);
    rd(1, 8'h00, "R8 off pin high");
    // R3 high level, R7 level ignores W1C
    setp(8'h03);
    idle(2);
    irq_chk(1, "R3 irq high");
    rd(1, 8'h01, "R3 pend high");
    wr(1, 8'h01);
    rd(1, 8'h01, "R7 level ignores clear");
    setp(8'h02);
    idle(2);
    rd(1, 8'h00, "R3 level gone");
    irq_chk(0, "R3 irq low");
    // R4 low level, R11 mode write clears
    wr(4, 8'h02);
    rd(1, 8'h00, "R11 write clears");
    rd(1, 8'h04, "R4 low sets");
    setp(8'h06);
    idle(2);
    rd(1, 8'h00, "R4 level gone");
    // R5 change mode, R6 port read
    wr(5, 8'h03);
    setp(8'h0E);
    idle(2);
    rd(1, 8'h08, "R5 change sets");
    irq_chk(1, "R5 irq");
    setp(8'h06);
    idle(3);
    rd(1, 8'h08, "R5 sticky");
    setp(8'h0E);
    idle(3);
    rd(0, 8'h0E, "R6 port read");
    rd(1, 8'h00, "R6 read clears");
    idle(2);
    rd(1, 8'h00, "R6 reference updated");
    // R7 write-one-to-clear
    setp(8'h06);
    idle(3);
    rd(1, 8'h08, "R7 set before clear");
    wr(1, 8'hF7);
    rd(1, 8'h08, "R7 zero bit kept");
    wr(1, 8'h08);
    rd(1, 8'h00, "R7 one bit cleared");
    rd(1, 8'h08, "R7 reference unchanged");
    // R11 mode rewrite
    wr(5, 8'h03);
    rd(1, 8'h00, "R11 rewrite clears");
    rd(1, 8'h08, "R11 resets after");
    // R9 combined request
    setp(8'h02);
    idle(2);
    rd(1, 8'h0C, "R9 two pending");
    irq_chk(1, "R9 irq two");
    rd(0, 8'h02, "R6 read port");
    rd(1, 8'h04, "R9 one left");
    irq_chk(1, "R9 irq one");
    setp(8'h06);
    idle(2);
    irq_chk(0, "R9 irq none");
    rd(1, 8'h00, "R9 pend none");
    // R10 second pin
    wr(9, 8'h1C);
    rd(9, 8'h1C, "R10 mode7 readback");
    drv_chk(24'hE00005, "R10 drive pin7");
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule